// File: doc/BRIEF.md
# Byte-Masked Page Memory Controller

This block puts a bank of 128-bit pages behind a small set of memory-mapped registers. Software fills four 32-bit staging registers and a 16-bit lane mask. It then issues a single command write that names a page and asks for a store, a fetch, or both. The controller moves only the bytes whose mask bit is set. Bytes that are masked off keep their old value at the destination. Each command write raises a completion flag, which software clears by writing a one to it. The page array is ordinary RAM with one port, sized by a parameter.

Each access is one cycle long. A read returns its data on `rsp_rdata` one cycle after the request. An access that is illegal returns zero and pulses `rsp_err` in that same cycle. An access is illegal if its offset has no register or its width does not suit the register. A page transfer finishes at the same clock edge that accepts the command, so the staging registers show fetched data to the next access.

Top module: `otp_page_ctrl`

## Requirements
- R1: After reset the registers read as follows: command 0x0000, lane mask 0xFFFF, status 0x0000, timing 0x00001485, and all four staging words zero.
- R2: The register map is fixed. Command is at offset 0x00, lane mask at 0x04 and status at 0x08; these three are 16-bit registers, accessed with `req_wide`=0 and read zero-extended. Timing is at 0x0C, and staging words 0 to 3 are at 0x80, 0x84, 0x88 and 0x8C; these are 32-bit registers, accessed with `req_wide`=1. Read data appears on `rsp_rdata` one cycle after the request.
- R3: A command write keeps only the bits in mask 0x39FF, and bits 8:0 of the written value select the page.
- R4: If a command write has bit 11 set, the store path runs. Each enabled byte of the staging image is copied into the selected page, and the disabled bytes of the page stay as they were.
- R5: If a command write has bit 12 set, the fetch path runs. Each enabled byte of the selected page is copied into the staging image, and this is visible to the very next access. Disabled staging bytes are left unchanged.
- R6: If both bit 11 and bit 12 are set, the store happens before the fetch. The page takes the enabled staging bytes, and the staging image is left unchanged.
- R7: Every accepted command write sets status bit 0, even when neither bit 11 nor bit 12 is set.
- R8: Each status bit is cleared by writing a one to it. Writing a zero to a status bit leaves it unchanged.
- R9: All 16 bits of the lane mask can be written. The timing register and the staging words are plain read/write registers.
- R10: Some accesses are illegal: those at an unmapped offset, and those whose width does not match the register. An illegal read returns zero, and an illegal write changes nothing. In both cases `rsp_err` goes high for exactly the one cycle after the request.
- R11: Lane mask bit n governs byte n of the page image. Byte 4k+j is bits 8j+7:8j of staging word k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside the block |
| req_valid | input | 1 | An access is presented this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | Access width: 1 = 32-bit, 0 = 16-bit |
| req_addr | input | 8 | Byte offset of the register |
| req_wdata | input | 32 | Write data; 16-bit writes use bits 15:0 |
| rsp_rdata | output | 32 | Read data, valid the cycle after a read, zero otherwise |
| rsp_err | output | 1 | One-cycle pulse for an illegal access |

## Verification
The bench checks partial lane masks, including a mask with a single lane set. A design that swaps byte order inside a word, or spreads the mask across the wrong word, fails these checks. The bench issues commands with both direction bits set, which catches a design that runs the fetch before the store and so brings stale page bytes back into the staging image. It writes zeros and then ones to the status register, which exposes a status bit that is cleared by an ordinary write or never cleared. It also makes accesses with the wrong width and at offsets between registers, then reads the target registers back. A design that performs those writes, or does not raise the error pulse, fails at that point.

// File: rtl/otp_pkg.sv
package otp_pkg;
  localparam int unsigned LANES    = 16;
  localparam int unsigned PAGE_W   = LANES * 8;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned NWORDS   = PAGE_W / WORD_W;
  localparam int unsigned HALF_W   = 16;

  localparam logic [HALF_W-1:0] CTRL_KEEP   = 16'h39FF;
  localparam int unsigned       CMD_STORE   = 11;
  localparam int unsigned       CMD_FETCH   = 12;
  localparam int unsigned       STAT_DONE   = 0;
  localparam logic [HALF_W-1:0] MASK_RST    = 16'hFFFF;
  localparam logic [WORD_W-1:0] TIMING_RST  = 32'h0000_1485;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CMD,
    SEL_MASK,
    SEL_STAT,
    SEL_TIME,
    SEL_STAGE
  } reg_sel_e;
endpackage

// File: rtl/otp_reg_decode.sv
module otp_reg_decode
  import otp_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wide,
  output reg_sel_e          sel,
  output logic [1:0]        word_idx,
  output logic              hit
);
  localparam logic [ADDR_W-1:0] OFF_CMD   = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] OFF_MASK  = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] OFF_STAT  = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] OFF_TIME  = ADDR_W'(8'h0C);
  localparam logic [ADDR_W-1:0] OFF_STAGE = ADDR_W'(8'h80);

  logic width_ok;

  always_comb begin
    sel      = SEL_NONE;
    width_ok = 1'b0;
    word_idx = addr[3:2];
    if (addr == OFF_CMD) begin
      sel      = SEL_CMD;
      width_ok = !wide;
    end else if (addr == OFF_MASK) begin
      sel      = SEL_MASK;
      width_ok = !wide;
    end else if (addr == OFF_STAT) begin
      sel      = SEL_STAT;
      width_ok = !wide;
    end else if (addr == OFF_TIME) begin
      sel      = SEL_TIME;
      width_ok = wide;
    end else if ((addr & ~ADDR_W'(8'h0C)) == OFF_STAGE) begin
      sel      = SEL_STAGE;
      width_ok = wide;
    end
    hit = (sel != SEL_NONE) && width_ok;
  end
endmodule

// File: rtl/otp_lane_merge.sv
module otp_lane_merge #(
  parameter int unsigned LANES = 16
) (
  input  logic [LANES*8-1:0] keep_img,
  input  logic [LANES*8-1:0] new_img,
  input  logic [LANES-1:0]   lane_en,
  output logic [LANES*8-1:0] out_img
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign out_img[g*8 +: 8] = lane_en[g] ? new_img[g*8 +: 8] : keep_img[g*8 +: 8];
  end
endmodule

// File: rtl/otp_page_store.sv
module otp_page_store #(
  parameter int unsigned PAGE_AW = 9,
  parameter int unsigned PAGE_W  = 128
) (
  input  logic               clk,
  input  logic [PAGE_AW-1:0] page,
  input  logic               we,
  input  logic [PAGE_W-1:0]  wr_img,
  output logic [PAGE_W-1:0]  rd_img
);
  localparam int unsigned DEPTH = 1 << PAGE_AW;

  logic [PAGE_W-1:0] cells [DEPTH];

  assign rd_img = cells[page];

  always_ff @(posedge clk) begin
    if (we) begin
      cells[page] <= wr_img;
    end
  end
endmodule

// File: rtl/otp_page_ctrl.sv
module otp_page_ctrl
  import otp_pkg::*;
#(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned PAGE_AW = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_wide,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic [31:0]       rsp_rdata,
  output logic              rsp_err
);
  // Reset: asserted asynchronously, released on a clock edge.
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  reg_sel_e          sel;
  logic [1:0]        word_idx;
  logic              dec_hit;

  otp_reg_decode #(.ADDR_W(ADDR_W)) i_decode (
    .addr     (req_addr),
    .wide     (req_wide),
    .sel      (sel),
    .word_idx (word_idx),
    .hit      (dec_hit)
  );

  logic [HALF_W-1:0] cmd_q, cmd_d, mask_q, mask_d, stat_q, stat_d;
  logic [WORD_W-1:0] time_q, time_d, rdata_d;
  logic [PAGE_W-1:0] stage_q, stage_d;
  logic              err_d;

  logic              wr_ok, rd_ok, cmd_wr, mem_we;
  logic [PAGE_AW-1:0] page_sel;
  logic [PAGE_W-1:0] page_rd, page_wr, fetch_src, fetch_img;

  assign wr_ok    = req_valid && req_write && dec_hit;
  assign rd_ok    = req_valid && !req_write && dec_hit;
  assign cmd_wr   = wr_ok && (sel == SEL_CMD);
  assign page_sel = req_wdata[PAGE_AW-1:0];
  assign mem_we   = cmd_wr && req_wdata[CMD_STORE];

  // Store path: enabled staging bytes over the current page contents.
  otp_lane_merge #(.LANES(LANES)) i_store_merge (
    .keep_img (page_rd),
    .new_img  (stage_q),
    .lane_en  (mask_q),
    .out_img  (page_wr)
  );

  // Fetch path sees the page after any store of the same command.
  assign fetch_src = req_wdata[CMD_STORE] ? page_wr : page_rd;

  otp_lane_merge #(.LANES(LANES)) i_fetch_merge (
    .keep_img (stage_q),
    .new_img  (fetch_src),
    .lane_en  (mask_q),
    .out_img  (fetch_img)
  );

  otp_page_store #(.PAGE_AW(PAGE_AW), .PAGE_W(PAGE_W)) i_store (
    .clk    (clk),
    .page   (page_sel),
    .we     (mem_we),
    .wr_img (page_wr),
    .rd_img (page_rd)
  );

  // Next-state logic.
  always_comb begin
    cmd_d   = cmd_q;
    mask_d  = mask_q;
    stat_d  = stat_q;
    time_d  = time_q;
    stage_d = stage_q;
    if (wr_ok) begin
      unique case (sel)
        SEL_CMD: begin
          cmd_d             = req_wdata[HALF_W-1:0] & CTRL_KEEP;
          stat_d[STAT_DONE] = 1'b1;
          if (req_wdata[CMD_FETCH]) stage_d = fetch_img;
        end
        SEL_MASK:  mask_d = req_wdata[HALF_W-1:0];
        SEL_STAT:  stat_d = stat_q & ~req_wdata[HALF_W-1:0];
        SEL_TIME:  time_d = req_wdata;
        SEL_STAGE: stage_d[word_idx*WORD_W +: WORD_W] = req_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_d = '0;
    if (rd_ok) begin
      unique case (sel)
        SEL_CMD:   rdata_d = {16'h0, cmd_q};
        SEL_MASK:  rdata_d = {16'h0, mask_q};
        SEL_STAT:  rdata_d = {16'h0, stat_q};
        SEL_TIME:  rdata_d = time_q;
        SEL_STAGE: rdata_d = stage_q[word_idx*WORD_W +: WORD_W];
        default:   rdata_d = '0;
      endcase
    end
    err_d = req_valid && !dec_hit;
  end

  // State registers.
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      cmd_q     <= '0;
      mask_q    <= MASK_RST;
      stat_q    <= '0;
      time_q    <= TIMING_RST;
      stage_q   <= '0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      if (wr_ok) begin
        cmd_q   <= cmd_d;
        mask_q  <= mask_d;
        stat_q  <= stat_d;
        time_q  <= time_d;
        stage_q <= stage_d;
      end
      rsp_rdata <= rdata_d;
      rsp_err   <= err_d;
    end
  end

  // Assertions guarding the register file.
  assert_cmd_keep_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && req_write && !req_wide && req_addr == '0)
      |=> (cmd_q == ($past(req_wdata[HALF_W-1:0]) & CTRL_KEEP)));

  assert_done_set_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && req_write && !req_wide && req_addr == '0) |=> stat_q[STAT_DONE]);

  assert_stat_clear_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && req_write && !req_wide && req_addr == ADDR_W'(8'h08) && req_wdata[STAT_DONE])
      |=> !stat_q[STAT_DONE]);

  assert_bad_write_ignored_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && req_write && !dec_hit)
      |=> ($stable(cmd_q) && $stable(mask_q) && $stable(stat_q) && $stable(time_q) && $stable(stage_q)));

  assert_err_zero_data_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rsp_err |-> (rsp_rdata == '0));

  assert_err_follows_bad_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && !dec_hit) |=> rsp_err);
endmodule

// File: tb/test_otp_page_ctrl.sv
module test_otp_page_ctrl;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_wide = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] rsp_rdata;
  logic        rsp_err;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // Bench reference state.
  logic [127:0] ref_mem [512];
  logic [127:0] ref_stage;
  logic [15:0]  ref_cmd, ref_mask, ref_stat;
  logic [31:0]  ref_time;

  always #(CLK_PERIOD/2) clk = ~clk;

  otp_page_ctrl i_otp_page_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_wide(req_wide), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_rdata(rsp_rdata), .rsp_err(rsp_err)
  );

  function automatic logic [127:0] lane_mix(logic [127:0] keep, logic [127:0] nw, logic [15:0] en);
    logic [127:0] r = keep;
    for (int i = 0; i < 16; i++) if (en[i]) r[i*8 +: 8] = nw[i*8 +: 8];
    return r;
  endfunction

  function automatic bit legal(logic wide, logic [7:0] a);
    if (!wide) return (a == 8'h00) || (a == 8'h04) || (a == 8'h08);
    return (a == 8'h0C) || (a == 8'h80) || (a == 8'h84) || (a == 8'h88) || (a == 8'h8C);
  endfunction

  function automatic logic [31:0] ref_read(logic [7:0] a);
    case (a)
      8'h00: return {16'h0, ref_cmd};
      8'h04: return {16'h0, ref_mask};
      8'h08: return {16'h0, ref_stat};
      8'h0C: return ref_time;
      default: return ref_stage[a[3:2]*32 +: 32];
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One bus cycle; inputs change at negedge, outputs sampled at the next negedge.
  task automatic bus(logic wr, logic wide, logic [7:0] a, logic [31:0] wd, string tag);
    bit ok = legal(wide, a);
    logic [31:0] exp_rd = '0;
    if (!wr && ok) exp_rd = ref_read(a);
    req_valid = 1'b1; req_write = wr; req_wide = wide; req_addr = a; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    check({tag, " err"}, {31'h0, rsp_err}, {31'h0, !ok});
    if (!wr) check({tag, " rdata"}, rsp_rdata, exp_rd);
    if (wr && ok) begin
      case (a)
        8'h00: begin
          logic [8:0] pg = wd[8:0];
          ref_cmd = wd[15:0] & 16'h39FF;
          ref_stat[0] = 1'b1;
          if (wd[11]) ref_mem[pg] = lane_mix(ref_mem[pg], ref_stage, ref_mask);
          if (wd[12]) ref_stage = lane_mix(ref_stage, ref_mem[pg], ref_mask);
        end
        8'h04: ref_mask = wd[15:0];
        8'h08: ref_stat = ref_stat & ~wd[15:0];
        8'h0C: ref_time = wd;
        default: ref_stage[a[3:2]*32 +: 32] = wd;
      endcase
    end
  endtask

  task automatic read_all(string tag);
    bus(0, 0, 8'h00, 0, tag); bus(0, 0, 8'h04, 0, tag); bus(0, 0, 8'h08, 0, tag);
    bus(0, 1, 8'h0C, 0, tag);
    for (int k = 0; k < 4; k++) bus(0, 1, 8'h80 + 8'(k*4), 0, tag);
  endtask

  function automatic logic [8:0] pick_page();
    int unsigned r = $urandom_range(0, 16);
    return (r == 16) ? 9'h1FF : 9'(r);
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'h5EED_0A1B));
    ref_cmd = 0; ref_mask = 16'hFFFF; ref_stat = 0; ref_time = 32'h0000_1485; ref_stage = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset values
    read_all("R1 reset");

    // Fill the pages the bench uses with full-mask stores (R4).
    for (int p = 0; p <= 16; p++) begin
      logic [8:0] pg = (p == 16) ? 9'h1FF : 9'(p);
      for (int k = 0; k < 4; k++) bus(1, 1, 8'h80 + 8'(k*4), $urandom, "R9 stage wr");
      bus(1, 0, 8'h00, {20'h0, 1'b1, 2'b00, pg}, "R4 fill");
    end

    // R11: single-lane fetch of byte 5 (word 1 bits 15:8)
    bus(1, 1, 8'h84, 32'h0, "R9 stage"); bus(1, 0, 8'h04, 32'h0000_0020, "R11 mask");
    bus(1, 0, 8'h00, {19'h0, 1'b1, 3'b000, 9'd3}, "R5 fetch");
    bus(0, 1, 8'h84, 0, "R11 lane5");
    bus(0, 1, 8'h80, 0, "R11 word0");

    // R4/R11: single-lane store of byte 15, then full fetch
    bus(1, 1, 8'h8C, 32'hA5C3_7E19, "R9 stage");
    bus(1, 0, 8'h04, 32'h0000_8000, "R11 mask");
    bus(1, 0, 8'h00, {20'h0, 1'b1, 2'b00, 9'd7}, "R4 store");
    bus(1, 0, 8'h04, 32'h0000_FFFF, "R9 mask");
    bus(1, 0, 8'h00, {19'h0, 1'b1, 3'b000, 9'd7}, "R5 fetch");
    read_all("R4 lane15");

    // R6: both bits at once, top page
    for (int k = 0; k < 4; k++) bus(1, 1, 8'h80 + 8'(k*4), $urandom, "R9 stage");
    bus(1, 0, 8'h04, 32'h0000_0F0F, "R11 mask");
    bus(1, 0, 8'h00, {19'h0, 2'b11, 2'b00, 9'h1FF}, "R6 both");
    read_all("R6 both");
    bus(1, 0, 8'h04, 32'h0000_FFFF, "R9 mask");
    bus(1, 0, 8'h00, {19'h0, 1'b1, 3'b000, 9'h1FF}, "R6 fetch");
    read_all("R6 page");

    // R8 then R7: zero writes keep, one clears, plain command sets, R3 mask
    bus(1, 0, 8'h08, 32'h0000_FFFE, "R8 w0"); bus(0, 0, 8'h08, 0, "R8 keep");
    bus(1, 0, 8'h08, 32'h0000_0001, "R8 w1"); bus(0, 0, 8'h08, 0, "R8 clear");
    bus(1, 0, 8'h00, 32'hFFFF_C605, "R7 plain"); bus(0, 0, 8'h08, 0, "R7 done");
    bus(0, 0, 8'h00, 0, "R3 keep");

    // R10: wrong widths and holes, then read back
    bus(1, 1, 8'h00, 32'h0000_1801, "R10 wide cmd");
    bus(1, 0, 8'h80, 32'h1234_5678, "R10 narrow stage");
    bus(1, 1, 8'h10, 32'hFFFF_FFFF, "R10 hole");
    bus(1, 0, 8'h02, 32'hFFFF_FFFF, "R10 odd");
    bus(0, 1, 8'h04, 0, "R10 wide rd"); bus(0, 0, 8'h0C, 0, "R10 narrow rd");
    bus(0, 1, 8'h90, 0, "R10 hole rd");
    read_all("R10 after");

    // Constrained random mix (R2..R11)
    for (int n = 0; n < 1500; n++) begin
      int unsigned op = $urandom_range(0, 9);
      case (op)
        0, 1: bus(1, 1, 8'h80 + 8'($urandom_range(0, 3) * 4), $urandom, "R9 stage");
        2: bus(1, 0, 8'h04, $urandom, "R9 mask");
        3, 4: bus(1, 0, 8'h00, {$urandom_range(0, 32'h7F_FFFF), pick_page()}, "R5 cmd");
        5: bus(1, 0, 8'h08, $urandom, "R8 stat");
        6: bus(1, 1, 8'h0C, $urandom, "R9 time");
        7: bus($urandom_range(0, 1), $urandom_range(0, 1), 8'($urandom), $urandom, "R10 any");
        default: begin
          logic [7:0] a;
          case ($urandom_range(0, 7))
            0: a = 8'h00; 1: a = 8'h04; 2: a = 8'h08; 3: a = 8'h0C;
            4: a = 8'h80; 5: a = 8'h84; 6: a = 8'h88; default: a = 8'h8C;
          endcase
          bus(0, a[7] | (a == 8'h0C), a, 0, "R2 read");
        end
      endcase
    end
    bus(1, 0, 8'h04, 32'h0000_FFFF, "R9 mask");
    for (int p = 0; p <= 16; p++) begin
      bus(1, 0, 8'h00, {19'h0, 1'b1, 3'b000, ((p == 16) ? 9'h1FF : 9'(p))}, "R5 sweep");
      read_all("R4 sweep");
    end

    finished = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule